// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs interrupt entry for a 16-bit little-endian processor core. Four request lines are read together as a 4-bit code. A fixed map turns each non-zero code into a priority level and a vector address. The level is compared against the priority field held in bits [7:5] of the status word, and the entry is taken only when the level is strictly higher.

Once an entry is taken, the sequencer works through a word-wide memory port behind a request/ready handshake. It first reads the new program counter and the new status word from the vector pair. It then pushes the old status word and the old program counter onto a stack that grows downward. Finally it loads the new values. When a core option is enabled, a query/acknowledge handshake lets an external agent replace the table vector.

The block owns the program counter, stack pointer and status word registers and gives them their reset values. The execution side of the core updates these registers through a load port while no entry is in progress. After each load the sequencer goes back to idle and evaluates the request code again, so a newly loaded low priority can allow a further, nested entry straight away.

Top module: `irq_entry_seq`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) sets sp_q to 0x00FE, psw_q to 0xE0, waiting to 0 and busy to 0. It sets pc_q from boot_mode: 0→0xC000, 1→0x8000, 2→0x4000, 3→0x2000, 4→0x1000, 5→0x0000, 6→0xF600, 7→0xF400.
- R2: The code map is fixed. Code 0 means no request. Codes 1,2,3 have level 4 and vectors 0x38, 0x34, 0x30. Codes 4..7 have level 5 and vectors 0x5C, 0x58, 0x54, 0x50. Codes 8..11 have level 6 and vectors 0x4C, 0x48, 0x44, 0x40. Codes 12..15 have level 7 and vectors 0x6C, 0x68, 0x64, 0x60.
- R3: An entry starts only when busy is low and the mapped level is strictly greater than psw_q[7:5]. An equal or lower level, or code 0, leaves busy low and the memory port idle.
- R4: Each entry makes exactly four transfers, in this order:
  - a read at vector V, which gives the new pc;
  - a read at V+2, which gives the new status in its low 8 bits;
  - a write of the zero-extended old status to sp_q-2;
  - a write of the old pc to sp_q-4.
  Each write lowers sp_q by 2.
- R5: A transfer completes in a cycle where mem_req and mem_rdy are both high. While mem_rdy is low, mem_req, mem_we and mem_addr hold steady.
- R6: Before the reads, vq_req is raised with vq_code equal to the latched code. On the cycle with vq_ack high, if vq_use is high then vq_vec replaces the table vector. The vector used always has its two low bits cleared.
- R7: Every memory address has bit 0 cleared.
- R8: After the fourth transfer, one load cycle copies the fetched pc and status into pc_q and psw_q. The block then returns to idle and evaluates the current code again, which allows an immediate nested entry.
- R9: Changes on irq_code while busy is high do not affect the running entry.
- R10: busy is high from the first cycle after the entry decision through the load cycle. done pulses for exactly the load cycle, with entry_cost reading 114.
- R11: A high wait_enter sets waiting. The load cycle of an entry clears it.
- R12: With ld_en high and busy low, pc_q, sp_q and psw_q take ld_pc, ld_sp and ld_psw at the next edge. While busy is high, ld_en is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 3 | Start-address select sampled during reset |
| irq_code | input | 4 | Request lines read as one code |
| wait_enter | input | 1 | Core entered its wait state |
| ld_en | input | 1 | Register load strobe from the execution side |
| ld_pc | input | 16 | Program counter load value |
| ld_sp | input | 16 | Stack pointer load value |
| ld_psw | input | 8 | Status word load value |
| vq_req | output | 1 | Vector query to an external agent |
| vq_code | output | 4 | Code being entered |
| vq_ack | input | 1 | Query answered |
| vq_use | input | 1 | Use vq_vec in place of the table vector |
| vq_vec | input | 16 | Replacement vector |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address, bit 0 cleared |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while mem_rdy is high |
| mem_rdy | input | 1 | Transfer completes this cycle |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| psw_q | output | 8 | Status word |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Load cycle of an entry |
| entry_cost | output | 8 | Cycle cost charged for an entry |
| waiting | output | 1 | Core is in its wait state |

## Verification
The assertions assume that memory completes every transfer eventually and that ld_en is never raised while busy is high. They also assume ld_en does not coincide with a request that is about to win, because a load in that cycle would change the stack pointer that the push checks expect. The stimulus applies register loads only after the code has been set to 0 or to a losing level, or while busy is high to test that the load is ignored. The ready line stalls in a rotating pattern so that the hold property sees many wait cycles. Each vector answer is given one cycle after the query appears.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_VEC    = 3'd1,
      ST_FPC    = 3'd2,
      ST_FPSW   = 3'd3,
      ST_PSHPSW = 3'd4,
      ST_PSHPC  = 3'd5,
      ST_LOAD   = 3'd6
   } seq_st_t;

   localparam int PRIO_LSB = 5;
   localparam int PRIO_W   = 3;
   localparam int CODE_W   = 4;

endpackage

// File: rtl/irq_prio_map.sv
module irq_prio_map
   import irq_entry_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [CODE_W-1:0] code,
   output logic [PRIO_W-1:0] level,
   output logic [AW-1:0]     vec
);

   logic [7:0] v8;

   always_comb begin
      level = 3'd0;
      v8    = 8'h00;
      case (code)
         4'd0:  begin level = 3'd0; v8 = 8'h00; end
         4'd1:  begin level = 3'd4; v8 = 8'h38; end
         4'd2:  begin level = 3'd4; v8 = 8'h34; end
         4'd3:  begin level = 3'd4; v8 = 8'h30; end
         4'd4:  begin level = 3'd5; v8 = 8'h5C; end
         4'd5:  begin level = 3'd5; v8 = 8'h58; end
         4'd6:  begin level = 3'd5; v8 = 8'h54; end
         4'd7:  begin level = 3'd5; v8 = 8'h50; end
         4'd8:  begin level = 3'd6; v8 = 8'h4C; end
         4'd9:  begin level = 3'd6; v8 = 8'h48; end
         4'd10: begin level = 3'd6; v8 = 8'h44; end
         4'd11: begin level = 3'd6; v8 = 8'h40; end
         4'd12: begin level = 3'd7; v8 = 8'h6C; end
         4'd13: begin level = 3'd7; v8 = 8'h68; end
         4'd14: begin level = 3'd7; v8 = 8'h64; end
         default: begin level = 3'd7; v8 = 8'h60; end
      endcase
   end

   assign vec = AW'(v8);

endmodule

// File: rtl/irq_boot_vec.sv
module irq_boot_vec #(
   parameter int AW = 16
) (
   input  logic [2:0]    mode,
   output logic [AW-1:0] start
);

   logic [15:0] s16;

   always_comb begin
      case (mode)
         3'd0:    s16 = 16'hC000;
         3'd1:    s16 = 16'h8000;
         3'd2:    s16 = 16'h4000;
         3'd3:    s16 = 16'h2000;
         3'd4:    s16 = 16'h1000;
         3'd5:    s16 = 16'h0000;
         3'd6:    s16 = 16'hF600;
         default: s16 = 16'hF400;
      endcase
   end

   assign start = AW'(s16);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_entry_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int PW     = 8,
   parameter bit OVR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CODE_W-1:0] code_in,
   input  logic [AW-1:0]     tbl_vec,
   input  logic              vq_ack,
   input  logic              vq_use,
   input  logic [AW-1:0]     vq_vec,
   input  logic              mem_rdy,
   input  logic [DW-1:0]     mem_rdata,
   input  logic [AW-1:0]     cur_sp,
   input  logic [AW-1:0]     cur_pc,
   input  logic [PW-1:0]     cur_psw,
   output seq_st_t           st,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic              vq_req,
   output logic [CODE_W-1:0] vq_code,
   output logic [AW-1:0]     nxt_pc,
   output logic [PW-1:0]     nxt_psw,
   output logic              push_step,
   output logic              load_now
);

   localparam logic [AW-1:0] WORD_MASK = ~AW'(1);
   localparam logic [AW-1:0] QUAD_MASK = ~AW'(3);
   localparam logic [AW-1:0] STEP      = AW'(2);
   localparam seq_st_t       FIRST_ST  = OVR_EN ? ST_VEC : ST_FPC;

   seq_st_t             st_q, st_d;
   logic [AW-1:0]       vec_q, vec_d;
   logic [CODE_W-1:0]   code_q;
   logic [AW-1:0]       npc_q;
   logic [PW-1:0]       npsw_q;
   logic                xfer;
   logic                ask_done;
   logic [AW-1:0]       ask_vec;

   // Variant: external vector query present or absent
   generate
      if (OVR_EN) begin : g_query
         assign vq_req   = (st_q == ST_VEC);
         assign vq_code  = code_q;
         assign ask_done = vq_ack;
         assign ask_vec  = vq_use ? (vq_vec & QUAD_MASK) : vec_q;
      end else begin : g_noquery
         assign vq_req   = 1'b0;
         assign vq_code  = '0;
         assign ask_done = 1'b1;
         assign ask_vec  = vec_q;
      end
   endgenerate

   assign xfer = mem_req & mem_rdy;

   always_comb begin
      st_d  = st_q;
      vec_d = vec_q;
      unique case (st_q)
         ST_IDLE: begin
            if (go) begin
               st_d  = FIRST_ST;
               vec_d = tbl_vec & QUAD_MASK;
            end
         end
         ST_VEC: begin
            if (ask_done) begin
               st_d  = ST_FPC;
               vec_d = ask_vec;
            end
         end
         ST_FPC:    if (xfer) st_d = ST_FPSW;
         ST_FPSW:   if (xfer) st_d = ST_PSHPSW;
         ST_PSHPSW: if (xfer) st_d = ST_PSHPC;
         ST_PSHPC:  if (xfer) st_d = ST_LOAD;
         ST_LOAD:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st_q)
         ST_FPC: begin
            mem_req  = 1'b1;
            mem_addr = vec_q & WORD_MASK;
         end
         ST_FPSW: begin
            mem_req  = 1'b1;
            mem_addr = (vec_q + STEP) & WORD_MASK;
         end
         ST_PSHPSW: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = (cur_sp - STEP) & WORD_MASK;
            mem_wdata = DW'(cur_psw);
         end
         ST_PSHPC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = (cur_sp - STEP) & WORD_MASK;
            mem_wdata = DW'(cur_pc);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         vec_q  <= '0;
         code_q <= '0;
         npc_q  <= '0;
         npsw_q <= '0;
      end else begin
         st_q  <= st_d;
         vec_q <= vec_d;
         if (st_q == ST_IDLE && go)
            code_q <= code_in;
         if (st_q == ST_FPC && xfer)
            npc_q <= AW'(mem_rdata);
         if (st_q == ST_FPSW && xfer)
            npsw_q <= mem_rdata[PW-1:0];
      end
   end

   assign st        = st_q;
   assign nxt_pc    = npc_q;
   assign nxt_psw   = npsw_q;
   assign push_step = xfer & mem_we;
   assign load_now  = (st_q == ST_LOAD);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int          AW         = 16,
   parameter int          DW         = 16,
   parameter int          PW         = 8,
   parameter bit          OVR_EN     = 1'b1,
   parameter int          ENTRY_COST = 114,
   parameter int          COST_W     = 8,
   parameter logic [15:0] SP_RESET   = 16'h00FE,
   parameter logic [7:0]  PSW_RESET  = 8'hE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        boot_mode,
   input  logic [CODE_W-1:0] irq_code,
   input  logic              wait_enter,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_pc,
   input  logic [AW-1:0]     ld_sp,
   input  logic [PW-1:0]     ld_psw,
   output logic              vq_req,
   output logic [CODE_W-1:0] vq_code,
   input  logic              vq_ack,
   input  logic              vq_use,
   input  logic [AW-1:0]     vq_vec,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_rdy,
   output logic [AW-1:0]     pc_q,
   output logic [AW-1:0]     sp_q,
   output logic [PW-1:0]     psw_q,
   output logic              busy,
   output logic              done,
   output logic [COST_W-1:0] entry_cost,
   output logic              waiting
);

   localparam logic [AW-1:0] STEP = AW'(2);

   // Elaboration-time parameter checks
   generate
      if (AW < 16) begin : g_bad_aw
         $error("irq_entry_seq: AW must be at least 16");
      end
      if (DW < AW || DW < PW) begin : g_bad_dw
         $error("irq_entry_seq: DW must hold a pc and a status word");
      end
      if (PW < PRIO_LSB + PRIO_W) begin : g_bad_pw
         $error("irq_entry_seq: PW too narrow for the priority field");
      end
      if (ENTRY_COST >= (1 << COST_W)) begin : g_bad_cost
         $error("irq_entry_seq: ENTRY_COST does not fit COST_W");
      end
   endgenerate

   seq_st_t           st;
   logic [PRIO_W-1:0] req_level;
   logic [PRIO_W-1:0] cur_level;
   logic [AW-1:0]     tbl_vec;
   logic [AW-1:0]     boot_pc;
   logic [AW-1:0]     nxt_pc;
   logic [PW-1:0]     nxt_psw;
   logic              push_step;
   logic              load_now;
   logic              go;

   irq_prio_map #(.AW(AW)) u_map (
      .code  (irq_code),
      .level (req_level),
      .vec   (tbl_vec)
   );

   irq_boot_vec #(.AW(AW)) u_boot (
      .mode  (boot_mode),
      .start (boot_pc)
   );

   assign cur_level = psw_q[PRIO_LSB +: PRIO_W];
   assign go        = (st == ST_IDLE) && (req_level > cur_level);

   irq_seq_fsm #(
      .AW     (AW),
      .DW     (DW),
      .PW     (PW),
      .OVR_EN (OVR_EN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .code_in   (irq_code),
      .tbl_vec   (tbl_vec),
      .vq_ack    (vq_ack),
      .vq_use    (vq_use),
      .vq_vec    (vq_vec),
      .mem_rdy   (mem_rdy),
      .mem_rdata (mem_rdata),
      .cur_sp    (sp_q),
      .cur_pc    (pc_q),
      .cur_psw   (psw_q),
      .st        (st),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .vq_req    (vq_req),
      .vq_code   (vq_code),
      .nxt_pc    (nxt_pc),
      .nxt_psw   (nxt_psw),
      .push_step (push_step),
      .load_now  (load_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= boot_pc;
         sp_q    <= AW'(SP_RESET);
         psw_q   <= PW'(PSW_RESET);
         waiting <= 1'b0;
      end else begin
         if (load_now) begin
            pc_q  <= nxt_pc;
            psw_q <= nxt_psw;
         end else if (push_step) begin
            sp_q <= sp_q - STEP;
         end else if (ld_en && st == ST_IDLE) begin
            pc_q  <= ld_pc;
            sp_q  <= ld_sp;
            psw_q <= ld_psw;
         end
         if (load_now)
            waiting <= 1'b0;
         else if (wait_enter)
            waiting <= 1'b1;
      end
   end

   assign busy       = (st != ST_IDLE);
   assign done       = load_now;
   assign entry_cost = COST_W'(ENTRY_COST);

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    irq_code,
   input logic          busy,
   input logic          done,
   input logic          waiting,
   input logic          vq_req,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_rdy,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] sp_q
);

   // R7
   a_r7_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);

   // R5
   a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R4
   a_r4_sp_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_rdy) |=> (sp_q == $past(sp_q) - AW'(2)));

   // R10
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !vq_req));

   // R10
   a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R3
   a_r3_no_code_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && irq_code == 4'd0) |=> !busy);

   // R11
   a_r11_wake_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !waiting);

endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_code (irq_code),
   .busy     (busy),
   .done     (done),
   .waiting  (waiting),
   .vq_req   (vq_req),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_rdy  (mem_rdy),
   .mem_addr (mem_addr),
   .sp_q     (sp_q)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [15:0] data;
   } xfer_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  boot_mode = 3'd6;
   logic [3:0]  irq_code = 4'd0;
   logic        wait_enter = 1'b0;
   logic        ld_en = 1'b0;
   logic [15:0] ld_pc = '0;
   logic [15:0] ld_sp = '0;
   logic [7:0]  ld_psw = '0;
   logic        vq_req;
   logic [3:0]  vq_code;
   logic        vq_ack = 1'b0;
   logic        vq_use = 1'b0;
   logic [15:0] vq_vec = '0;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rdy = 1'b0;
   logic [15:0] pc_q, sp_q;
   logic [7:0]  psw_q;
   logic        busy, done, waiting;
   logic [7:0]  entry_cost;

   int n_cmp = 0;
   int n_bad = 0;
   int n_done = 0;
   bit busy_seen = 1'b0;
   logic [7:0]  rdy_pat = 8'b1101_0110;
   logic [15:0] mem [0:127];
   xfer_t       exp_q [$];

   always #4 clk = ~clk;

   irq_entry_seq i_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .irq_code(irq_code),
      .wait_enter(wait_enter), .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp),
      .ld_psw(ld_psw), .vq_req(vq_req), .vq_code(vq_code), .vq_ack(vq_ack),
      .vq_use(vq_use), .vq_vec(vq_vec), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rdy(mem_rdy), .pc_q(pc_q), .sp_q(sp_q), .psw_q(psw_q), .busy(busy),
      .done(done), .entry_cost(entry_cost), .waiting(waiting)
   );

   assign mem_rdata = mem[mem_addr[7:1]];

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // table vector from the R2 rule, in arithmetic form
   function automatic logic [15:0] exp_vec(input logic [3:0] c);
      logic [15:0] base;
      if (c[3:2] == 2'd0) return 16'h003C - 16'(4 * c[1:0]);
      base = (c[3:2] == 2'd1) ? 16'h0050 : (c[3:2] == 2'd2) ? 16'h0040 : 16'h0060;
      return base + 16'(4 * (3 - c[1:0]));
   endfunction

   function automatic logic [15:0] exp_boot(input logic [2:0] m);
      case (m)
         3'd0: return 16'hC000; 3'd1: return 16'h8000;
         3'd2: return 16'h4000; 3'd3: return 16'h2000;
         3'd4: return 16'h1000; 3'd5: return 16'h0000;
         3'd6: return 16'hF600; default: return 16'hF400;
      endcase
   endfunction

   // driver: push the four transfers one entry must make (R4)
   task automatic expect_entry(input logic [15:0] v, input logic [15:0] old_pc,
                               input logic [7:0] old_psw, input logic [15:0] old_sp);
      exp_q.push_back('{we: 1'b0, addr: v, data: 16'h0});
      exp_q.push_back('{we: 1'b0, addr: v + 16'd2, data: 16'h0});
      exp_q.push_back('{we: 1'b1, addr: old_sp - 16'd2, data: {8'h00, old_psw}});
      exp_q.push_back('{we: 1'b1, addr: old_sp - 16'd4, data: old_pc});
   endtask

   // ready stalls and vector answers, moved away from the active edge
   always @(posedge clk) begin
      #2;
      rdy_pat = {rdy_pat[0], rdy_pat[7:1]};
      mem_rdy = rdy_pat[0];
      vq_ack  = vq_req && !vq_ack;
   end

   always @(posedge clk)
      if (mem_req && mem_rdy && mem_we) mem[mem_addr[7:1]] <= mem_wdata;

   // monitor: pop and compare every completed transfer
   always @(negedge clk) begin
      if (busy) busy_seen = 1'b1;
      if (rst_n && done) begin
         n_done++;
         chk(entry_cost == 8'd114, "R10 entry_cost", 32'(entry_cost), 32'd114);
      end
      if (rst_n && mem_req && mem_rdy) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected transfer", 32'(mem_addr), 32'hFFFF);
         end else begin
            xfer_t e;
            e = exp_q.pop_front();
            chk(mem_we == e.we, "R4 direction", 32'(mem_we), 32'(e.we));
            chk(mem_addr == e.addr, "R4 address", 32'(mem_addr), 32'(e.addr));
            if (e.we)
               chk(mem_wdata == e.data, "R4 write data", 32'(mem_wdata), 32'(e.data));
         end
      end
   end

   task automatic do_reset(input logic [2:0] m);
      @(negedge clk);
      rst_n = 1'b0; boot_mode = m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pc_q == exp_boot(m), "R1 start pc", 32'(pc_q), 32'(exp_boot(m)));
   endtask

   task automatic load_regs(input logic [15:0] p, input logic [15:0] s, input logic [7:0] w);
      @(negedge clk);
      ld_en = 1'b1; ld_pc = p; ld_sp = s; ld_psw = w;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic wait_level(input bit lvl);
      int k = 0;
      while (busy != lvl && k < 400) begin
         @(negedge clk);
         k++;
      end
      chk(busy == lvl, "R10 busy level", 32'(busy), 32'(lvl));
   endtask

   task automatic check_regs(input string req, input logic [15:0] p,
                             input logic [15:0] s, input logic [7:0] w);
      chk(pc_q == p, req, 32'(pc_q), 32'(p));
      chk(sp_q == s, req, 32'(sp_q), 32'(s));
      chk(psw_q == w, req, 32'(psw_q), 32'(w));
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
      mem[8'h38 >> 1] = 16'h2000; mem[8'h3A >> 1] = 16'h00A0;
      mem[8'h44 >> 1] = 16'h3000; mem[8'h46 >> 1] = 16'h0000;
      mem[8'h5C >> 1] = 16'h4000; mem[8'h5E >> 1] = 16'h0000;
      mem[8'h68 >> 1] = 16'h5000; mem[8'h6A >> 1] = 16'h00E0;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      // R1: reset values for several start modes
      do_reset(3'd2);
      do_reset(3'd5);
      do_reset(3'd6);
      check_regs("R1 reset regs", 16'hF600, 16'h00FE, 8'hE0);
      chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
      chk(waiting == 1'b0, "R1 waiting after reset", 32'(waiting), 32'd0);

      // R3: level 7 against status level 7 does not enter
      busy_seen = 1'b0;
      @(negedge clk); irq_code = 4'd15;
      repeat (10) @(negedge clk);
      chk(!busy_seen, "R3 equal level blocked", 32'(busy_seen), 32'd0);
      irq_code = 4'd0;

      // R12: load port while idle
      load_regs(16'h1234, 16'h00F0, 8'h00);
      check_regs("R12 load idle", 16'h1234, 16'h00F0, 8'h00);

      // R2 R4 R8: code 1, table vector; R12 load ignored while busy
      vq_use = 1'b0;
      expect_entry(exp_vec(4'd1), 16'h1234, 8'h00, 16'h00F0);
      @(negedge clk); irq_code = 4'd1;
      wait_level(1'b1);
      load_regs(16'hDEAD, 16'h0010, 8'hFF);
      wait_level(1'b0);
      check_regs("R8 R12 after code 1 entry", 16'h2000, 16'h00EC, 8'hA0);
      // R3: level 4 now below status level 5
      busy_seen = 1'b0;
      repeat (8) @(negedge clk);
      chk(!busy_seen, "R3 lower level blocked", 32'(busy_seen), 32'd0);
      irq_code = 4'd0;

      // R3: equal level 4 blocked
      load_regs(16'h2000, 16'h00EC, 8'h80);
      busy_seen = 1'b0;
      @(negedge clk); irq_code = 4'd3;
      repeat (8) @(negedge clk);
      chk(!busy_seen, "R3 equal level 4 blocked", 32'(busy_seen), 32'd0);
      irq_code = 4'd0;

      // R11: wait state set
      @(negedge clk); wait_enter = 1'b1;
      @(negedge clk); wait_enter = 1'b0;
      chk(waiting == 1'b1, "R11 wait set", 32'(waiting), 32'd1);

      // R6 R9: override vector 0x47 -> 0x44, code dropped mid-entry
      vq_use = 1'b1; vq_vec = 16'h0047;
      expect_entry(16'h0044, 16'h2000, 8'h80, 16'h00EC);
      @(negedge clk); irq_code = 4'd8;
      wait_level(1'b1);
      chk(vq_code == 4'd8, "R6 query code", 32'(vq_code), 32'd8);
      irq_code = 4'd13;
      @(negedge clk); irq_code = 4'd0;
      wait_level(1'b0);
      vq_use = 1'b0;
      check_regs("R6 R9 after override entry", 16'h3000, 16'h00E8, 8'h00);
      chk(waiting == 1'b0, "R11 wait cleared by entry", 32'(waiting), 32'd0);

      // R8: nested entry when the loaded status still admits the code
      begin
         int d0;
         d0 = n_done;
         expect_entry(exp_vec(4'd4), 16'h3000, 8'h00, 16'h00E8);
         expect_entry(exp_vec(4'd4), 16'h4000, 8'h00, 16'h00E4);
         @(negedge clk); irq_code = 4'd4;
         wait_level(1'b1);
         wait_level(1'b0);
         wait_level(1'b1);
         irq_code = 4'd0;
         wait_level(1'b0);
         chk(n_done == d0 + 2, "R8 nested entry count", 32'(n_done), 32'(d0 + 2));
         check_regs("R8 after nested entry", 16'h4000, 16'h00E0, 8'h00);
      end

      // R2: code 13 at status level 2
      load_regs(16'h4000, 16'h00E0, 8'h40);
      expect_entry(exp_vec(4'd13), 16'h4000, 8'h40, 16'h00E0);
      @(negedge clk); irq_code = 4'd13;
      wait_level(1'b1);
      wait_level(1'b0);
      irq_code = 4'd0;
      check_regs("R2 after code 13 entry", 16'h5000, 16'h00DC, 8'hE0);
      chk(mem[8'hDE >> 1] == 16'h0040, "R4 pushed status in memory",
          32'(mem[8'hDE >> 1]), 32'h40);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all transfers seen", 32'(exp_q.size()), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule